// File: doc/BRIEF.md
# Quasi-Resonant Flyback Switching Sequencer

This block is the digital heart of a valley-switched flyback primary controller. Every analog quantity reaches it as a one-bit comparator flag: the demagnetization sense pin above its arming level, below its firing level, or pulled below its shutdown level; the current-sense voltage above the peak-current threshold or above the short-circuit level; and the supply above its start and stop thresholds. A 3-bit band code tells it how high the error-amplifier output currently is. From these flags it drives one gate-enable bit.

A switching cycle turns on when the sense pin, once armed by a rise, falls through the firing level. It can also turn on when a restart timer expires after a long quiet spell. The cycle ends when the current-sense flag trips, once a short leading-edge window has passed. After each turn-off the firing logic is deaf for a blanking interval whose length grows as the band code falls. At light load this stretches the off-time, so ringing valleys are skipped and the switching frequency drops. A short-circuit level trip shuts the gate off for good, until the supply has gone through a full lockout and restart. Holding the sense pin at the shutdown level parks the block until it is released.

All times are counted in clock cycles of a clock whose frequency is known; the parameters set them.

Top module: `qr_sequencer`

## Requirements
- R1: After reset the block is in lockout (`st_lockout`=1, `gate_en`=0). It leaves lockout only on a cycle where `sup_above_start`=1. It re-enters lockout only on a cycle where `sup_above_stop`=0. While in lockout the gate is low from the next cycle on.
- R2: A turn-on from the sense pin needs arming first. `zcd_above_arm`=1 outside blanking and with the gate low sets `st_armed` on the next cycle. A later cycle with `zcd_below_fire`=1 while armed raises `gate_en` one cycle later. `zcd_below_fire` without prior arming leaves the gate low.
- R3: On the cycle `gate_en` falls, `st_blank` rises and stays high for the blanking length. Any arming seen while `st_blank`=1 is discarded: `st_armed` stays 0.
- R4: The blanking length is BLANK_MIN + (7 − band) × BLANK_STEP cycles. The band is sampled on the falling edge of the gate, so band 7 (highest control voltage) gives the shortest length and band 0 the longest.
- R5: While running with the gate low, a starter fires a pulse exactly START_CYC cycles after the gate went low, or after running began, if no sense-pin trigger came first. Each turn-on restarts this count.
- R6: `cs_above_peak` turns the gate off on the next cycle, except during the first LEB_CYC cycles of the on-time, when it is ignored. With the flag held high from turn-on, the gate stays high for LEB_CYC+1 cycles.
- R7: The gate latch is reset-dominant. A trigger arriving in the same cycle as `cs_above_peak`=1 while the gate is low leaves the gate low.
- R8: `cs_above_short`=1 while out of lockout sets `st_hiccup` and forces the gate low on the next cycle. The gate then stays low, whatever triggers or starter periods follow, until lockout is entered. Lockout clears `st_hiccup` one cycle later.
- R9: `zcd_below_off`=1 sets `st_disabled` on the next cycle and keeps the gate low, with the starter silent. After release the starter fires START_CYC cycles after `st_disabled` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_start | input | 1 | Supply above the start threshold |
| sup_above_stop | input | 1 | Supply above the stop threshold |
| zcd_above_arm | input | 1 | Sense pin above the arming level |
| zcd_below_fire | input | 1 | Sense pin below the firing level |
| zcd_below_off | input | 1 | Sense pin pulled below the shutdown level |
| cs_above_peak | input | 1 | Current sense above the peak-current threshold |
| cs_above_short | input | 1 | Current sense above the short-circuit level |
| comp_band | input | 3 | Control-voltage band, 7 = highest |
| gate_en | output | 1 | Gate enable for the power switch driver |
| st_armed | output | 1 | Firing logic armed |
| st_blank | output | 1 | Post-turn-off blanking active |
| st_hiccup | output | 1 | Short-circuit shutdown latched |
| st_disabled | output | 1 | Shutdown by the sense pin active |
| st_lockout | output | 1 | Undervoltage lockout active |

## Verification
The hardest situation to reach from the ports is a short-circuit trip followed by triggers and full starter periods. The gate must remain dead through all of them, and only a supply dip into lockout and a fresh start may revive it. The stimulus lets the starter produce a pulse, pulses the short-circuit flag during that on-time, then arms and fires the sense pin and waits past a whole starter period. Only after that does it drop and restore the supply flags. Blanking discard is reached by arming inside the window opened by a peak-current turn-off, then offering a fire edge after the window closes.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
    typedef logic [2:0] band_t;
    localparam int unsigned NUM_BANDS = 8;

    typedef struct packed {
        logic lock;
        logic hic;
        logic dis;
    } sup_state_t;
endpackage

// File: rtl/qrs_supervisor.sv
module qrs_supervisor
    import qrs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sup_above_start,
    input  logic sup_above_stop,
    input  logic cs_above_short,
    input  logic zcd_below_off,
    output logic lockout,
    output logic hiccup,
    output logic disabled,
    output logic run
);
    sup_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.lock = st_q.lock ? !sup_above_start : !sup_above_stop;
        st_d.hic  = st_q.lock ? 1'b0 : (st_q.hic | cs_above_short);
        st_d.dis  = zcd_below_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lock: 1'b1, hic: 1'b0, dis: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lockout  = st_q.lock;
    assign hiccup   = st_q.hic;
    assign disabled = st_q.dis;
    assign run      = !st_q.lock && !st_q.hic && !st_q.dis;

    // R8: the short-circuit latch holds until lockout
    assert_hiccup_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hic && !st_q.lock) |=> st_q.hic);
    // R8: lockout clears the latch
    assert_hiccup_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> !st_q.hic);
endmodule

// File: rtl/qrs_trigger.sv
module qrs_trigger
    import qrs_pkg::*;
#(
    parameter int unsigned BLANK_MIN  = 175,
    parameter int unsigned BLANK_STEP = 104,
    parameter int unsigned START_CYC  = 20000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  gate,
    input  logic  gate_off_now,
    input  logic  zcd_above_arm,
    input  logic  zcd_below_fire,
    input  band_t band,
    output logic  set_req,
    output logic  start_fire,
    output logic  armed,
    output logic  blanking
);
    localparam int unsigned BLANK_MAX = BLANK_MIN + (NUM_BANDS - 1) * BLANK_STEP;
    localparam int unsigned BW        = $clog2(BLANK_MAX + 1);
    localparam int unsigned SW        = $clog2(START_CYC);
    localparam logic [SW-1:0] AGE_LAST = SW'(START_CYC - 1);

    logic [BW-1:0] len_tab [NUM_BANDS];

    for (genvar g = 0; g < NUM_BANDS; g++) begin : g_len
        assign len_tab[g] = BW'(BLANK_MIN + (NUM_BANDS - 1 - g) * BLANK_STEP);
    end

    typedef struct packed {
        logic          armed;
        logic [BW-1:0] blank;
        logic [SW-1:0] age;
    } trg_state_t;

    trg_state_t tq_d, tq_q;
    logic fire_ok;

    always_comb begin
        tq_d       = tq_q;
        blanking   = (tq_q.blank != '0);
        start_fire = !gate && (tq_q.age == AGE_LAST);
        fire_ok    = tq_q.armed && zcd_below_fire;
        set_req    = fire_ok || start_fire;

        if (!run || gate || blanking || fire_ok) begin
            tq_d.armed = 1'b0;
        end else begin
            tq_d.armed = tq_q.armed | zcd_above_arm;
        end

        if (gate_off_now) begin
            tq_d.blank = len_tab[band];
        end else if (blanking) begin
            tq_d.blank = tq_q.blank - 1'b1;
        end else begin
            tq_d.blank = '0;
        end

        if (!run || gate) begin
            tq_d.age = '0;
        end else if (tq_q.age != AGE_LAST) begin
            tq_d.age = tq_q.age + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tq_q <= '0;
        end else begin
            tq_q <= tq_d;
        end
    end

    assign armed = tq_q.armed;

    // R3: nothing stays armed inside the blanking window
    assert_blank_disarms_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blanking |-> !tq_q.armed);
    // R4: a falling gate always opens a window
    assert_blank_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off_now |=> blanking);
endmodule

// File: rtl/qrs_gate_latch.sv
module qrs_gate_latch #(
    parameter int unsigned LEB_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic set_req,
    input  logic cs_above_peak,
    input  logic cs_above_short,
    output logic gate,
    output logic gate_off_now
);
    localparam int unsigned LW = $clog2(LEB_CYC + 1);

    typedef struct packed {
        logic          gate;
        logic [LW-1:0] leb;
    } lat_state_t;

    lat_state_t lq_d, lq_q;
    logic peak_reset;

    always_comb begin
        lq_d       = lq_q;
        peak_reset = cs_above_peak && (lq_q.leb == '0);
        lq_d.gate  = run && !cs_above_short && !peak_reset && (lq_q.gate || set_req);

        if (!lq_d.gate) begin
            lq_d.leb = '0;
        end else if (!lq_q.gate) begin
            lq_d.leb = LW'(LEB_CYC);
        end else if (lq_q.leb != '0) begin
            lq_d.leb = lq_q.leb - 1'b1;
        end

        gate_off_now = lq_q.gate && !lq_d.gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lq_q <= '0;
        end else begin
            lq_q <= lq_d;
        end
    end

    assign gate = lq_q.gate;

    // R6: the gate only drops for a current trip or loss of run
    assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lq_q.gate) |-> $past(cs_above_peak || cs_above_short || !run));
    // R7: a peak flag while off keeps the gate off
    assert_reset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lq_q.gate && cs_above_peak) |=> !lq_q.gate);
endmodule

// File: rtl/qr_sequencer.sv
module qr_sequencer
    import qrs_pkg::*;
#(
    parameter int unsigned BLANK_MIN  = 175,
    parameter int unsigned BLANK_STEP = 104,
    parameter int unsigned START_CYC  = 20000,
    parameter int unsigned LEB_CYC    = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sup_above_start,
    input  logic       sup_above_stop,
    input  logic       zcd_above_arm,
    input  logic       zcd_below_fire,
    input  logic       zcd_below_off,
    input  logic       cs_above_peak,
    input  logic       cs_above_short,
    input  logic [2:0] comp_band,
    output logic       gate_en,
    output logic       st_armed,
    output logic       st_blank,
    output logic       st_hiccup,
    output logic       st_disabled,
    output logic       st_lockout
);
    logic run_w, set_w, fire_w, off_now_w;

    qrs_supervisor u_sup (
        .clk             (clk),
        .rst_n           (rst_n),
        .sup_above_start (sup_above_start),
        .sup_above_stop  (sup_above_stop),
        .cs_above_short  (cs_above_short),
        .zcd_below_off   (zcd_below_off),
        .lockout         (st_lockout),
        .hiccup          (st_hiccup),
        .disabled        (st_disabled),
        .run             (run_w)
    );

    qrs_trigger #(
        .BLANK_MIN  (BLANK_MIN),
        .BLANK_STEP (BLANK_STEP),
        .START_CYC  (START_CYC)
    ) u_trg (
        .clk            (clk),
        .rst_n          (rst_n),
        .run            (run_w),
        .gate           (gate_en),
        .gate_off_now   (off_now_w),
        .zcd_above_arm  (zcd_above_arm),
        .zcd_below_fire (zcd_below_fire),
        .band           (comp_band),
        .set_req        (set_w),
        .start_fire     (fire_w),
        .armed          (st_armed),
        .blanking       (st_blank)
    );

    qrs_gate_latch #(
        .LEB_CYC (LEB_CYC)
    ) u_lat (
        .clk            (clk),
        .rst_n          (rst_n),
        .run            (run_w),
        .set_req        (set_w),
        .cs_above_peak  (cs_above_peak),
        .cs_above_short (cs_above_short),
        .gate           (gate_en),
        .gate_off_now   (off_now_w)
    );

    // R1: lockout holds the gate low
    assert_lockout_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_lockout |=> !gate_en);
    // R8: the short-circuit latch holds the gate low
    assert_hiccup_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_hiccup |=> !gate_en);
    // R9: shutdown by the sense pin holds the gate low
    assert_disable_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_disabled |=> !gate_en);
    // R2 / R5: every turn-on comes from an armed fire or the starter
    assert_turn_on_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past((st_armed && zcd_below_fire) || fire_w));
endmodule

// File: tb/qr_sequencer_tb.sv
module qr_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BMIN  = 6;
    localparam int BSTEP = 3;
    localparam int SCYC  = 120;
    localparam int LEB   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_on = 0, vcc_off = 0, z_arm = 0, z_fire = 0, z_off = 0, c_pk = 0, c_sc = 0;
    logic [2:0] band = 3'd7;
    logic gate, armed, blank, hic, dis, lock;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qr_sequencer #(.BLANK_MIN(BMIN), .BLANK_STEP(BSTEP), .START_CYC(SCYC), .LEB_CYC(LEB)) u_dut (
        .clk(clk), .rst_n(rst_n), .sup_above_start(vcc_on), .sup_above_stop(vcc_off),
        .zcd_above_arm(z_arm), .zcd_below_fire(z_fire), .zcd_below_off(z_off),
        .cs_above_peak(c_pk), .cs_above_short(c_sc), .comp_band(band),
        .gate_en(gate), .st_armed(armed), .st_blank(blank), .st_hiccup(hic),
        .st_disabled(dis), .st_lockout(lock));

    // behavioural reference, advanced on each rising edge
    bit m_lock, m_hic, m_dis, m_gate, m_armed;
    int m_blank_left, m_quiet, m_leb_left;

    function automatic int win_len(input int b);
        return BMIN + (7 - b) * BSTEP;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lock = 1; m_hic = 0; m_dis = 0; m_gate = 0; m_armed = 0;
            m_blank_left = 0; m_quiet = 0; m_leb_left = 0;
        end else begin
            bit running, fired, started, on_next, was_on;
            running = !m_lock && !m_hic && !m_dis;
            started = !m_gate && (m_quiet == SCYC - 1);
            fired   = m_armed && z_fire;
            on_next = running && !c_sc && !(c_pk && m_leb_left == 0) && (m_gate || fired || started);
            was_on  = m_gate;
            if (!running || m_gate || m_blank_left > 0 || fired) m_armed = 0;
            else if (z_arm) m_armed = 1;
            if (was_on && !on_next) m_blank_left = win_len(band);
            else if (m_blank_left > 0) m_blank_left--;
            if (!running || m_gate) m_quiet = 0;
            else if (m_quiet < SCYC - 1) m_quiet++;
            if (!on_next) m_leb_left = 0;
            else if (!was_on) m_leb_left = LEB;
            else if (m_leb_left > 0) m_leb_left--;
            m_gate = on_next;
            m_hic  = m_lock ? 0 : (m_hic || c_sc);
            m_lock = m_lock ? !vcc_on : !vcc_off;
            m_dis  = z_off;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
        if (rst_n) begin
            check(gate  == m_gate,            "R6 gate vs model",    gate,  m_gate);
            check(armed == m_armed,           "R2 armed vs model",   armed, m_armed);
            check(blank == (m_blank_left > 0),"R3 blank vs model",   blank, m_blank_left > 0);
            check(hic   == m_hic,             "R8 hiccup vs model",  hic,   m_hic);
            check(dis   == m_dis,             "R9 disable vs model", dis,   m_dis);
            check(lock  == m_lock,            "R1 lockout vs model", lock,  m_lock);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (!gate && n < 2000) begin n++; tick(); end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (gate && n < 2000) begin n++; tick(); end
    endtask

    task automatic count_blank(output int n);
        n = 0;
        while (blank && n < 2000) begin n++; tick(); z_arm = 0; end
    endtask

    int n;
    bit seen;

    initial begin
        ticks(3);
        rst_n = 1'b1;
        tick();
        check(lock == 1 && gate == 0, "R1 reset state lockout", lock, 1);

        vcc_off = 1; ticks(4);
        check(lock == 1, "R1 stop level alone keeps lockout", lock, 1);
        vcc_on = 1; tick(); vcc_on = 0;
        check(lock == 0, "R1 start level leaves lockout", lock, 0);

        count_low(n);
        check(n == SCYC, "R5 first starter pulse delay", n, SCYC);

        c_pk = 1;
        count_high(n);
        c_pk = 0;
        check(n == LEB + 1, "R6 peak flag masked in leading edge", n, LEB + 1);

        z_arm = 1;
        count_blank(n);
        check(n == win_len(7), "R4 window length band 7", n, win_len(7));
        check(armed == 0, "R3 arming inside window discarded", armed, 0);
        z_fire = 1; ticks(2);
        check(gate == 0, "R2 fire without arming ignored", gate, 0);
        z_fire = 0;

        z_arm = 1; tick(); z_arm = 0; tick();
        check(armed == 1, "R2 arming after window", armed, 1);
        z_fire = 1; tick(); z_fire = 0;
        check(gate == 1, "R2 armed fire turns gate on", gate, 1);

        band = 3'd0;
        ticks(LEB);
        c_pk = 1; tick(); c_pk = 0;
        check(gate == 0, "R6 peak flag after leading edge", gate, 0);
        count_blank(n);
        check(n == win_len(0), "R4 window length band 0", n, win_len(0));
        band = 3'd3;

        z_arm = 1; tick(); z_arm = 0; tick();
        z_fire = 1; c_pk = 1; ticks(2);
        check(gate == 0, "R7 reset wins over simultaneous fire", gate, 0);
        z_fire = 0; c_pk = 0; tick();

        z_arm = 1; tick(); z_arm = 0; tick();
        z_fire = 1; tick(); z_fire = 0;
        ticks(LEB);
        c_pk = 1; tick(); c_pk = 0;
        check(gate == 0, "R5 pulse ended before starter count", gate, 0);
        count_low(n);
        check(n == SCYC, "R5 starter restarts at each turn-on", n, SCYC);

        c_sc = 1; tick(); c_sc = 0;
        check(gate == 0 && hic == 1, "R8 short trip latches", hic, 1);
        seen = 0;
        z_arm = 1; tick(); z_arm = 0; tick(); z_fire = 1; tick(); z_fire = 0;
        for (int i = 0; i < SCYC + 20; i++) begin tick(); if (gate) seen = 1; end
        check(seen == 0, "R8 gate stays off after trip", seen, 0);

        vcc_off = 0; ticks(2);
        check(lock == 1 && hic == 0, "R8 lockout clears latch", hic, 0);
        vcc_off = 1; vcc_on = 1; tick(); vcc_on = 0;
        count_low(n);
        check(n == SCYC, "R8 restart after lockout cycle", n, SCYC);

        z_off = 1; ticks(2);
        check(dis == 1 && gate == 0, "R9 shutdown forces gate low", gate, 0);
        seen = 0;
        for (int i = 0; i < SCYC + 20; i++) begin tick(); if (gate) seen = 1; end
        check(seen == 0, "R9 starter silent while shut down", seen, 0);
        z_off = 0; tick();
        check(dis == 0, "R9 release clears shutdown", dis, 0);
        count_low(n);
        check(n == SCYC, "R9 resume after release", n, SCYC);

        c_pk = 1; ticks(LEB + 2); c_pk = 0; ticks(4);
        finish_run();
    end
endmodule